// File: doc/BRIEF.md
# Condition Code Evaluator

This block turns a 4-bit condition selector and five arithmetic status flags (carry, zero, sign, overflow, parity) into a single truth bit and a result byte. The byte is 0x01 when the selected condition holds and 0x00 when it does not. It sits next to the flag register of an integer execution unit. A set-on-condition operation passes the low nibble of its opcode as the selector and writes the byte back through the normal result path. No flag is changed.

The sixteen selector values form eight pairs. Selector bits [3:1] pick one base relation: overflow, carry, zero, unsigned below-or-equal, sign, parity, signed less, or signed less-or-equal. Selector bit 0 inverts the sense of that relation. The same encoding therefore covers both the unsigned and the signed comparisons. The block is purely combinational. The result follows the inputs in the same cycle.

Top module: `cond_code_eval`

## Requirements
- R1: Selector 0x0 gives true when flag_ovf is 1. Selector 0x1 gives true when flag_ovf is 0.
- R2: Selector 0x2 gives true when flag_carry is 1. Selector 0x3 gives true when flag_carry is 0.
- R3: Selector 0x4 gives true when flag_zero is 1. Selector 0x5 gives true when flag_zero is 0.
- R4: Selector 0x6 gives true when flag_carry or flag_zero is 1. Selector 0x7 gives true when both are 0.
- R5: Selector 0x8 gives true when flag_sign is 1, and 0x9 when it is 0. Selector 0xA gives true when flag_parity is 1, and 0xB when it is 0.
- R6: Selector 0xC gives true when flag_sign differs from flag_ovf. Selector 0xD gives true when they are equal.
- R7: Selector 0xE gives true when flag_zero is 1 or flag_sign differs from flag_ovf. Selector 0xF gives true when neither holds.
- R8: cond_byte bit 0 equals cond_true and every other bit of cond_byte is 0. The byte is therefore 0x01 or 0x00.
- R9: For any flag values, each odd selector 2k+1 yields the exact complement of selector 2k.
- R10: Flags that the chosen selector does not name have no effect on cond_true or cond_byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cond_sel | input | 4 | Condition selector (low nibble of the set-on-condition opcode) |
| flag_carry | input | 1 | Carry flag |
| flag_zero | input | 1 | Zero flag |
| flag_sign | input | 1 | Sign flag |
| flag_ovf | input | 1 | Overflow flag |
| flag_parity | input | 1 | Parity flag |
| cond_true | output | 1 | Selected condition holds |
| cond_byte | output | 8 | 0x01 when the condition holds, else 0x00 |

## Verification
The block holds no state. A wrong base term or a wrong inversion shows up at the output in the same cycle, for the particular selector and flag combination that exposes it. The bench therefore sweeps all 512 selector and flag combinations. This means a single miswired pair entry, a dropped inversion, or a stray upper byte bit cannot escape. The bench also compares each odd selector against the even selector just before it, under identical flags.

// File: rtl/ccx_pkg.sv
package ccx_pkg;

    localparam int SEL_W  = 4;
    localparam int BYTE_W = 8;
    localparam int PAIR_W = SEL_W - 1;
    localparam int PAIR_N = 1 << PAIR_W;

    typedef struct packed {
        logic cy;
        logic zr;
        logic sg;
        logic ov;
        logic pa;
    } flags_t;

    // Base relation chosen by selector bits [3:1]; bit 0 inverts it.
    typedef enum logic [PAIR_W-1:0] {
        PAIR_OVF   = 3'd0,
        PAIR_CARRY = 3'd1,
        PAIR_ZERO  = 3'd2,
        PAIR_ULE   = 3'd3,
        PAIR_SIGN  = 3'd4,
        PAIR_PAR   = 3'd5,
        PAIR_SLT   = 3'd6,
        PAIR_SLE   = 3'd7
    } pair_e;

    function automatic logic signed_lt(input flags_t f);
        return f.sg ^ f.ov;
    endfunction

    function automatic pair_e pair_of(input logic [SEL_W-1:0] sel);
        return pair_e'(sel[SEL_W-1:1]);
    endfunction

    function automatic logic sense_inv(input logic [SEL_W-1:0] sel);
        return sel[0];
    endfunction

endpackage

// File: rtl/ccx_base_terms.sv
module ccx_base_terms
    import ccx_pkg::*;
(
    input  flags_t            flags,
    output logic [PAIR_N-1:0] base
);

    always_comb begin
        base             = '0;
        base[PAIR_OVF]   = flags.ov;
        base[PAIR_CARRY] = flags.cy;
        base[PAIR_ZERO]  = flags.zr;
        base[PAIR_ULE]   = flags.cy | flags.zr;
        base[PAIR_SIGN]  = flags.sg;
        base[PAIR_PAR]   = flags.pa;
        base[PAIR_SLT]   = signed_lt(flags);
        base[PAIR_SLE]   = flags.zr | signed_lt(flags);
    end

endmodule

// File: rtl/ccx_pair_select.sv
module ccx_pair_select
    import ccx_pkg::*;
(
    input  logic [SEL_W-1:0]  sel,
    input  logic [PAIR_N-1:0] base,
    output logic              hit
);

    pair_e pair;

    always_comb begin
        pair = pair_of(sel);
        hit  = base[pair] ^ sense_inv(sel);
    end

endmodule

// File: rtl/ccx_byte_pack.sv
module ccx_byte_pack #(
    parameter int OUT_W = 8
) (
    input  logic             hit,
    output logic [OUT_W-1:0] packed_out
);

    for (genvar i = 0; i < OUT_W; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            assign packed_out[i] = hit;
        end else begin : g_zero
            assign packed_out[i] = 1'b0;
        end
    end

endmodule

// File: rtl/cond_code_eval.sv
module cond_code_eval
    import ccx_pkg::*;
(
    input  logic [SEL_W-1:0]  cond_sel,
    input  logic              flag_carry,
    input  logic              flag_zero,
    input  logic              flag_sign,
    input  logic              flag_ovf,
    input  logic              flag_parity,
    output logic              cond_true,
    output logic [BYTE_W-1:0] cond_byte
);

    flags_t            flags;
    logic [PAIR_N-1:0] base;
    logic              hit;

    always_comb begin
        flags.cy = flag_carry;
        flags.zr = flag_zero;
        flags.sg = flag_sign;
        flags.ov = flag_ovf;
        flags.pa = flag_parity;
    end

    ccx_base_terms u_terms (
        .flags (flags),
        .base  (base)
    );

    ccx_pair_select u_sel (
        .sel  (cond_sel),
        .base (base),
        .hit  (hit)
    );

    ccx_byte_pack #(.OUT_W(BYTE_W)) u_pack (
        .hit        (hit),
        .packed_out (cond_byte)
    );

    assign cond_true = hit;

endmodule

// File: rtl/cond_code_eval_chk.sv
module cond_code_eval_chk
    import ccx_pkg::*;
(
    input logic [SEL_W-1:0]  cond_sel,
    input logic              flag_carry,
    input logic              flag_zero,
    input logic              flag_sign,
    input logic              flag_ovf,
    input logic              flag_parity,
    input logic              cond_true,
    input logic [BYTE_W-1:0] cond_byte
);

    always_comb begin
        if (cond_sel == 4'h0) p_ovf_set_r1: assert (cond_true == flag_ovf);
        if (cond_sel == 4'h3) p_carry_clr_r2: assert (cond_true == !flag_carry);
        if (cond_sel == 4'h4) p_zero_set_r3: assert (cond_true == flag_zero);
        if (cond_sel == 4'h7) p_above_r4: assert (cond_true == (!flag_carry && !flag_zero));
        if (cond_sel == 4'hA) p_parity_set_r5: assert (cond_true == flag_parity);
        if (cond_sel == 4'hD) p_sge_r6: assert (cond_true == (flag_sign == flag_ovf));
        if (cond_sel == 4'hE) p_sle_r7: assert (cond_true == (flag_zero || (flag_sign != flag_ovf)));
        p_byte_form_r8: assert (cond_byte == {{(BYTE_W-1){1'b0}}, cond_true});
    end

endmodule

bind cond_code_eval cond_code_eval_chk u_chk (
    .cond_sel    (cond_sel),
    .flag_carry  (flag_carry),
    .flag_zero   (flag_zero),
    .flag_sign   (flag_sign),
    .flag_ovf    (flag_ovf),
    .flag_parity (flag_parity),
    .cond_true   (cond_true),
    .cond_byte   (cond_byte)
);

// File: tb/cond_code_eval_tb_top.sv
module cond_code_eval_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] cond_sel = '0;
    logic       flag_carry = 0, flag_zero = 0, flag_sign = 0, flag_ovf = 0, flag_parity = 0;
    logic       cond_true;
    logic [7:0] cond_byte;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit obs_even [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    cond_code_eval dut_i (
        .cond_sel    (cond_sel),
        .flag_carry  (flag_carry),
        .flag_zero   (flag_zero),
        .flag_sign   (flag_sign),
        .flag_ovf    (flag_ovf),
        .flag_parity (flag_parity),
        .cond_true   (cond_true),
        .cond_byte   (cond_byte)
    );

    // flag vector f: bit4 carry, bit3 zero, bit2 sign, bit1 ovf, bit0 parity
    function automatic bit model(input int sel, input int f);
        bit c = f[4], z = f[3], s = f[2], o = f[1], p = f[0];
        bit r;
        case (sel / 2)
            0: r = o;
            1: r = c;
            2: r = z;
            3: r = c | z;
            4: r = s;
            5: r = p;
            6: r = (s != o);
            default: r = z | (s != o);
        endcase
        return (sel % 2 == 1) ? !r : r;
    endfunction

    function automatic string req_of(input int sel);
        case (sel / 2)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4, 5: return "R5";
            6: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s sel=%0h flags=%b%b%b%b%b actual=%0h expected=%0h", req, cond_sel,
                     flag_carry, flag_zero, flag_sign, flag_ovf, flag_parity, act, exp);
        end
    endtask

    task automatic apply(input int sel, input int f);
        @(negedge clk);
        cond_sel    = 4'(sel);
        flag_carry  = f[4];
        flag_zero   = f[3];
        flag_sign   = f[2];
        flag_ovf    = f[1];
        flag_parity = f[0];
        #(CLK_PERIOD/4);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // idle inputs: selector 0 with all flags clear gives false, byte 0x00
        apply(0, 0);
        check("R1", cond_byte, 8'h00);

        // full sweep compared every clock with the behavioural model
        for (int sel = 0; sel < 16; sel++) begin
            for (int f = 0; f < 32; f++) begin
                bit e;
                apply(sel, f);
                e = model(sel, f);
                check(req_of(sel), cond_true, e);
                check("R8", cond_byte, {7'b0, e});
                if (sel % 2 == 0) obs_even[f] = cond_true;
                else check("R9", cond_true, !obs_even[f]);
            end
        end

        // R10: unnamed flags toggled around a fixed named flag leave output unchanged
        for (int f = 0; f < 32; f++) begin
            apply(4'h4, f | 5'b01000);
            check("R10", cond_byte, 8'h01);
            apply(4'hA, f & 5'b11110);
            check("R10", cond_true, 0);
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule